// File: doc/BRIEF.md
# Half-Cycle Resolution PWM Generator

This block produces a pulse-width-modulated line whose duty word has 9 bits of resolution. One PWM period is 512 slots but lasts only 256 cycles of a single clock. Each clock cycle carries two slots: the high phase of the clock holds an even slot and the low phase holds an odd slot. The block reaches this rate without a faster clock: it evaluates the compare in a rising-edge flop and in a falling-edge flop, then merges the two flops with an XOR encoding, so the clock never gates any logic directly.

The output is low while the slot index is below the active duty word and high from that slot on. A larger duty word therefore gives a shorter high time. A new duty word takes effect only at a period boundary. The current cycle number is brought out for debug.

Top module: `hslot_pwm`

## Requirements
- R1: Slot index s runs 0..511 in each period. Slot 2k is the high half of clock cycle k and slot 2k+1 is its low half. During slot s the output is 1 when s >= active duty and 0 otherwise.
- R2: An odd slot result holds through the low phase of the clock. It is set by the falling edge, and the next rising edge replaces it with the even-slot result.
- R3: The duty word is captured only at the rising edge that starts cycle 0. Any change at other times has no effect on the output until the next period starts.
- R4: A duty word of 0 gives an output that is high in all 512 slots of the period.
- R5: A duty word of 511 gives an output that is high only in slot 511, which is the low half of cycle 255.
- R6: The output is high in exactly 512 - d slots of a period with duty d. For example, d = 255 gives 257 slots and d = 510 gives 2 slots.
- R7: Reset is asynchronous and active high. It forces the output to 0 and the cycle number to 255 without waiting for a clock edge. The first rising edge after release starts cycle 0 of a new period.
- R8: The cycle number output steps by one on each rising edge and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Asynchronous active-high reset |
| duty_in | input | 9 | Duty word; the output is low for slots below this value |
| pwm_o | output | 1 | PWM line, driven only by flops |
| phase_o | output | 8 | Current clock cycle number within the period (debug) |

## Verification
The duty capture at the period boundary and the slot-0 compare fall in the same rising edge. Slot 0 must therefore use the word that has just been captured, not the one in force before it. The bench provokes this by changing duty_in in the last cycle of every period. It also scrambles duty_in at random points inside some periods. Every even and odd slot is compared against a model that captures the word only at the boundary, and each period's total count of high slots is checked against 512 - d.

// File: rtl/hslot_pwm_pkg.sv
package hslot_pwm_pkg;

    // Compare results for the two half-cycle slots of one clock cycle
    typedef struct packed {
        logic even_hi;  // slot 2k is at or above the duty word
        logic odd_hi;   // slot 2k+1 is at or above the duty word
    } slot_dec_t;

    // XOR encoding: the new value for one flop, given the other flop,
    // so that the XOR of the two flops equals the wanted level
    function automatic logic xor_target(input logic want, input logic other);
        return want ^ other;
    endfunction

endpackage

// File: rtl/hslot_cycle_ctr.sv
module hslot_cycle_ctr #(
    parameter int DUTY_W = 9,
    localparam int CNT_W = DUTY_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic [DUTY_W-1:0] duty_q,
    output logic [DUTY_W-1:0] duty_nxt
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_last;

    always_comb begin
        at_last  = (cnt_q == CNT_LAST);
        cnt_nxt  = cnt_q + CNT_ONE;
        duty_nxt = at_last ? duty_in : duty_q;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q  <= CNT_LAST;
            duty_q <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
            duty_q <= duty_nxt;
        end
    end

    // R8: counter steps by one on every rising edge
    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R8: wrap from the last cycle to cycle 0
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_LAST) |=> (cnt_q == '0));

    // R3: the active duty word holds inside a period
    p_hold_duty_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != CNT_LAST) |=> $stable(duty_q));

    // R3: the duty word is loaded at the period boundary
    p_load_duty_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_LAST) |=> (duty_q == $past(duty_in)));

endmodule

// File: rtl/hslot_slot_cmp.sv
module hslot_slot_cmp
    import hslot_pwm_pkg::*;
#(
    parameter int DUTY_W = 9,
    localparam int CNT_W = DUTY_W - 1
) (
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [DUTY_W-1:0] duty_q,
    input  logic [DUTY_W-1:0] duty_nxt,
    output slot_dec_t         dec
);
    // Even slot: the value that the next rising edge loads (cycle and duty)
    // Odd slot: the current cycle, used at the falling edge
    always_comb begin
        dec.even_hi = ({cnt_nxt, 1'b0} >= duty_nxt);
        dec.odd_hi  = ({cnt_q,   1'b1} >= duty_q);
    end

endmodule

// File: rtl/hslot_merge.sv
module hslot_merge
    import hslot_pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_dec_t dec,
    output logic      pwm_o
);
    logic rise_q;
    logic fall_q;

    // Only one flop changes at each edge, so the XOR cannot glitch
    always_ff @(posedge clk or posedge rst) begin
        if (rst) rise_q <= 1'b0;
        else     rise_q <= xor_target(dec.even_hi, fall_q);
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= xor_target(dec.odd_hi, rise_q);
    end

    assign pwm_o = rise_q ^ fall_q;

endmodule

// File: rtl/hslot_pwm.sv
module hslot_pwm
    import hslot_pwm_pkg::*;
#(
    parameter int DUTY_W = 9,
    localparam int CNT_W = DUTY_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm_o,
    output logic [CNT_W-1:0]  phase_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [DUTY_W-1:0] duty_act;
    logic [DUTY_W-1:0] duty_nxt;
    slot_dec_t         dec;

    hslot_cycle_ctr #(.DUTY_W(DUTY_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .duty_in  (duty_in),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .duty_q   (duty_act),
        .duty_nxt (duty_nxt)
    );

    hslot_slot_cmp #(.DUTY_W(DUTY_W)) u_cmp (
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .duty_q   (duty_act),
        .duty_nxt (duty_nxt),
        .dec      (dec)
    );

    hslot_merge u_merge (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .pwm_o (pwm_o)
    );

    assign phase_o = cnt_q;

    // R1: at the end of the high phase the output shows the even slot
    p_even_slot_r1: assert property (@(negedge clk) disable iff (rst)
        !$past(rst) |-> (pwm_o == ({phase_o, 1'b0} >= duty_act)));

    // R2: at the end of the low phase the output shows the odd slot
    p_odd_slot_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pwm_o == ({phase_o, 1'b1} >= duty_act)));

endmodule

// File: tb/hslot_pwm_bench.sv
`timescale 1ns/1ps
module hslot_pwm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] duty_in = 9'd0;
    logic       pwm_o;
    logic [7:0] phase_o;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int seed_init;

    always #10 clk = ~clk;   // 50 MHz

    hslot_pwm u_hslot_pwm (
        .clk     (clk),
        .rst     (rst),
        .duty_in (duty_in),
        .pwm_o   (pwm_o),
        .phase_o (phase_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int slot_level(input int slot, input int d);
        return (slot >= d) ? 1 : 0;
    endfunction

    function automatic string tag_for(input int d);
        if (d == 0)   return "R4 high count";
        if (d == 511) return "R5 high count";
        return "R6 high count";
    endfunction

    // One period; duty_in becomes next_d in the last cycle (R3 boundary),
    // optionally scrambled at random points inside the period
    task automatic run_period(input logic [8:0] next_d, input bit scramble);
        int exp_d = 0;
        int highs = 0;
        for (int k = 0; k < 256; k++) begin
            @(posedge clk); #5;
            if (k == 0) exp_d = int'(duty_in);
            check("R1 even slot", int'(pwm_o), slot_level(2*k, exp_d));
            check("R8 phase", int'(phase_o), k);
            highs += int'(pwm_o);
            @(negedge clk); #2;
            if (k == 255) duty_in = next_d;
            else if (scramble && ($urandom % 8 == 0)) duty_in = 9'($urandom);
            #3;
            check(scramble ? "R3 odd slot after scramble" : "R2 odd slot",
                  int'(pwm_o), slot_level(2*k+1, exp_d));
            highs += int'(pwm_o);
        end
        check(tag_for(exp_d), highs, 512 - exp_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] plan [0:12];
        bit         scr  [0:12];
        seed_init = $urandom(32'd1234);
        plan[0] = 9'd0;   plan[1] = 9'd1;   plan[2] = 9'd255;
        plan[3] = 9'd510; plan[4] = 9'd511;
        for (int i = 5; i < 12; i++) plan[i] = 9'($urandom);
        plan[12] = 9'd0;
        for (int i = 0; i < 13; i++) scr[i] = (i >= 5 && i < 12);

        // R7: state while reset is held
        repeat (3) @(posedge clk);
        #5;
        check("R7 reset output", int'(pwm_o), 0);
        check("R7 reset phase", int'(phase_o), 255);
        @(negedge clk); #2;
        duty_in = plan[0];
        rst = 1'b0;

        for (int p = 0; p < 13; p++)
            run_period((p < 12) ? plan[p+1] : 9'd300, scr[p]);

        // R7: asynchronous reset while the output is high (duty 300, slot 0 low:
        // move to a high slot first)
        repeat (200) @(posedge clk);
        #5;
        check("R7 pre-reset output high", int'(pwm_o), 1);
        rst = 1'b1;
        #1;
        check("R7 async reset output", int'(pwm_o), 0);
        check("R7 async reset phase", int'(phase_o), 255);
        repeat (2) @(posedge clk);
        @(negedge clk); #2;
        duty_in = 9'd511;
        rst = 1'b0;
        run_period(9'd255, 1'b0);
        run_period(9'd255, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule